// File: doc/BRIEF.md
# Timed Serial Register Access Master

This block lets on-chip logic read and write the registers of a metering-style peripheral over a four-wire serial link made of an active-low select, a serial clock, a master-to-peripheral data line and a peripheral-to-master data line. The requester gives a direction, a 6-bit register address, a byte count of one to three and, for writes, the data. It then pulses `start`. The master lowers the select and shifts out a command byte. It then moves the data bytes, most significant byte first and most significant bit first, and finally raises the select. After that it reports `done` and presents any read data right-justified.

Every interval on the link is counted in system clock cycles and set by a parameter. These intervals are the select setup and hold, the clock high and low phases, the gap between data bytes, and the pause between a read command and its first data byte. That pause is long for ordinary registers and shorter for one designated waveform register. The defaults assume a 50 MHz system clock. The serial clock idles high whenever the select is high.

Top module: `regser_master`

## Requirements
- R1: During and right after reset, `cs_n` and `sclk` are 1, and `busy`, `done` and `rdata` are 0.
- R2: The first byte of each frame is the command: bit 7 is 1 for a write and 0 for a read, bit 6 is 0, and bits 5..0 hold `addr`.
- R3: A frame carries `nbytes` data bytes after the command, where an `nbytes` of 0 counts as 1. Write bytes come from `wdata` right-justified and go out most significant byte first, with each byte most significant bit first.
- R4: `mosi` never changes at a falling edge of `sclk` or while `sclk` is low. It is stable for at least `HALF_CYC` cycles before each falling edge.
- R5: On reads, `miso` is sampled as `sclk` falls. The bytes are assembled in arrival order, right-justified in `rdata`, and the unused upper bits are 0.
- R6: At least `CS_SETUP` cycles pass from the fall of `cs_n` to the first falling edge of `sclk`. Every high and low phase of `sclk` within a byte lasts at least `HALF_CYC` cycles.
- R7: After a read command, at least `RD_WAIT` cycles pass from its last rising edge of `sclk` to the first falling edge of the data. When `addr` equals `WAVE_ADDR`, `RD_WAIT_WAVE` is used instead. The interval exceeds the chosen value by no more than `HALF_CYC`.
- R8: The same interval is at least `BYTE_GAP` cycles between two data bytes and between a write command and its first data byte.
- R9: At least `CS_HOLD` cycles pass from the last falling edge of `sclk` to the rise of `cs_n`, and `sclk` is high whenever `cs_n` is high.
- R10: `busy` is high from the cycle after an accepted `start` until `done`. A `start` seen while `busy` is high is ignored and produces no frame.
- R11: `done` is high for exactly one cycle, the cycle after `cs_n` returns high, and `rdata` holds the result in that cycle. After a write, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a transaction (accepted only while not busy) |
| rd | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Register address |
| nbytes | input | 2 | Number of data bytes (0 is treated as 1) |
| wdata | input | 24 | Write data, right-justified |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 24 | Read result, right-justified |
| cs_n | output | 1 | Active-low select |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Data to peripheral |
| miso | input | 1 | Data from peripheral |

## Verification
After `start` is accepted, `busy` and the fall of `cs_n` appear one cycle later, and the first falling edge of `sclk` comes `CS_SETUP + HALF_CYC` cycles after that. Each data-phase interval ends exactly its gap plus `HALF_CYC` cycles after the preceding rising edge. `done` follows the rise of `cs_n` by exactly one cycle. The bench's peripheral model timestamps every edge of `cs_n` and `sclk` with a cycle counter, sampling half a period after the active clock edge. It then compares the differences against the lower bounds, and against the upper bound where one is required. `busy`, `done` and `rdata` are checked in the exact cycle they are due, and once more a cycle later for the pulse width.

// File: rtl/regser_pkg.sv
package regser_pkg;

  localparam int ADDR_W = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_GAP,
    ST_HOLD,
    ST_FIN
  } st_t;

  // Command byte: direction in bit 7 (1 = write), bit 6 zero, address below.
  function automatic logic [7:0] cmd_byte(input logic is_rd, input logic [ADDR_W-1:0] a);
    return {~is_rd, 1'b0, a};
  endfunction

endpackage

// File: rtl/regser_timer.sv
module regser_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          zero
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero); // R6

endmodule

// File: rtl/regser_shreg.sv
module regser_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= d;
    else if (shift) q <= {q[W-2:0], sin};
  end

endmodule

// File: rtl/regser_master.sv
module regser_master
  import regser_pkg::*;
#(
  parameter int HALF_CYC     = 3,
  parameter int CS_SETUP     = 3,
  parameter int CS_HOLD      = 5,
  parameter int BYTE_GAP     = 3,
  parameter int RD_WAIT      = 200,
  parameter int RD_WAIT_WAVE = 25,
  parameter logic [5:0] WAVE_ADDR = 6'h01,
  parameter int MAX_BYTES    = 3,
  localparam int DATA_W      = 8 * MAX_BYTES,
  localparam int CNT_W       = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd,
  input  logic [5:0]        addr,
  input  logic [CNT_W-1:0]  nbytes,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);

  localparam int T01  = (HALF_CYC > CS_SETUP) ? HALF_CYC : CS_SETUP;
  localparam int T02  = (CS_HOLD > BYTE_GAP) ? CS_HOLD : BYTE_GAP;
  localparam int T03  = (RD_WAIT > RD_WAIT_WAVE) ? RD_WAIT : RD_WAIT_WAVE;
  localparam int T04  = (T01 > T02) ? T01 : T02;
  localparam int TMAX = (T04 > T03) ? T04 : T03;
  localparam int TW   = $clog2(TMAX + 1);

  st_t               st;
  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_val;
  logic              sh_load, sh_shift;
  logic [7:0]        sh_d, sh_q, nxt_byte;
  logic [2:0]        bitc;
  logic [CNT_W-1:0]  left;
  logic              is_cmd, rd_q;
  logic [5:0]        addr_q;
  logic [DATA_W-1:0] wd_q, acc;
  logic [TW-1:0]     cmd_gap;

  regser_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  regser_shreg #(.W(8)) u_sh (
    .clk(clk), .rst(rst), .load(sh_load), .d(sh_d),
    .shift(sh_shift), .sin(miso), .q(sh_q)
  );

  // Next write byte: the highest remaining byte of the right-justified word.
  always_comb begin
    nxt_byte = '0;
    for (int k = 0; k < MAX_BYTES; k++)
      if (left == CNT_W'(k + 1)) nxt_byte = wd_q[8*k +: 8];
  end

  assign cmd_gap = !rd_q                ? TW'(BYTE_GAP - 1) :
                   (addr_q == WAVE_ADDR) ? TW'(RD_WAIT_WAVE - 1) :
                                           TW'(RD_WAIT - 1);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_d     = '0;
    sh_shift = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(CS_SETUP - 1);
        sh_load  = 1'b1;
        sh_d     = cmd_byte(rd, addr);
      end
      ST_SETUP: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(HALF_CYC - 1);
      end
      ST_HIGH: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(HALF_CYC - 1);
        sh_shift = 1'b1;
      end
      ST_LOW: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (bitc != 3'd0)          tmr_val = TW'(HALF_CYC - 1);
        else if (is_cmd)           tmr_val = cmd_gap;
        else if (left == CNT_W'(1)) tmr_val = TW'(CS_HOLD - 1);
        else                       tmr_val = TW'(BYTE_GAP - 1);
      end
      ST_GAP: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(HALF_CYC - 1);
        sh_load  = 1'b1;
        sh_d     = nxt_byte;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cs_n   <= 1'b1;
      sclk   <= 1'b1;
      mosi   <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      rdata  <= '0;
      bitc   <= '0;
      left   <= '0;
      is_cmd <= 1'b0;
      rd_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      acc    <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          busy   <= 1'b1;
          cs_n   <= 1'b0;
          rd_q   <= rd;
          addr_q <= addr;
          wd_q   <= wdata;
          if (nbytes == '0)                    left <= CNT_W'(1);
          else if (nbytes > CNT_W'(MAX_BYTES)) left <= CNT_W'(MAX_BYTES);
          else                                 left <= nbytes;
          is_cmd <= 1'b1;
          bitc   <= 3'd7;
          acc    <= '0;
          st     <= ST_SETUP;
        end
        ST_SETUP: if (tmr_zero) begin
          mosi <= sh_q[7];
          st   <= ST_HIGH;
        end
        ST_HIGH: if (tmr_zero) begin
          sclk <= 1'b0;
          st   <= ST_LOW;
        end
        ST_LOW: if (tmr_zero) begin
          sclk <= 1'b1;
          if (bitc != 3'd0) begin
            bitc <= bitc - 3'd1;
            mosi <= sh_q[7];
            st   <= ST_HIGH;
          end else begin
            bitc <= 3'd7;
            if (is_cmd) begin
              is_cmd <= 1'b0;
              st     <= ST_GAP;
            end else begin
              if (rd_q) acc <= {acc[DATA_W-9:0], sh_q};
              left <= left - CNT_W'(1);
              st   <= (left == CNT_W'(1)) ? ST_HOLD : ST_GAP;
            end
          end
        end
        ST_GAP: if (tmr_zero) begin
          mosi <= nxt_byte[7];
          st   <= ST_HIGH;
        end
        ST_HOLD: if (tmr_zero) begin
          cs_n <= 1'b1;
          st   <= ST_FIN;
        end
        ST_FIN: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          rdata <= acc;
          st    <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk); // R9
  AST_MOSI_HELD_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> $stable(mosi)); // R4
  AST_MOSI_HELD_LOW: assert property (@(posedge clk) disable iff (rst)
    (!sclk && !$fell(sclk)) |-> $stable(mosi)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && $past(cs_n))); // R11
  AST_FRAME_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !cs_n) |=> busy); // R10

endmodule

// File: tb/regser_master_bench.sv
module regser_master_bench;

  localparam int HALF  = 3;
  localparam int SETUP = 3;
  localparam int HOLD  = 5;
  localparam int GAP   = 3;
  localparam int RDW   = 200;
  localparam int RDWW  = 25;
  localparam logic [5:0] WAVE = 6'h01;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, rd = 1'b0;
  logic [5:0] addr = '0;
  logic [1:0] nbytes = '0;
  logic [23:0] wdata = '0;
  logic busy, done, cs_n, sclk, mosi;
  logic miso = 1'b0;
  logic [23:0] rdata;

  always #10 clk = ~clk;

  regser_master u_regser_master (
    .clk(clk), .rst(rst), .start(start), .rd(rd), .addr(addr),
    .nbytes(nbytes), .wdata(wdata), .busy(busy), .done(done),
    .rdata(rdata), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  bit ended = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural peripheral: timestamps edges, captures mosi, drives miso after rises.
  logic [31:0] pat = '0, got = '0;
  int fall_c[32], rise_c[32];
  int nf = 0, nr = 0, csf = 0, csr = 0, frames = 0, mchg = 0;
  int hold_err = 0, setup_err = 0;
  logic ps = 1'b1, pc = 1'b1, pm = 1'b0;

  always @(negedge clk) begin
    if (pc && !cs_n) begin
      csf = cyc; nf = 0; nr = 0; got = '0; hold_err = 0; setup_err = 0;
      miso = pat[31];
    end
    if (!pc && cs_n) begin
      csr = cyc; frames++;
    end
    if (mosi !== pm) begin
      mchg = cyc;
      if (!ps && !sclk) hold_err++;
    end
    if (ps && !sclk) begin
      if (nf < 32) fall_c[nf] = cyc;
      got = {got[30:0], mosi};
      if (cyc - mchg < HALF) setup_err++;
      nf++;
    end
    if (!ps && sclk) begin
      if (nr < 32) rise_c[nr] = cyc;
      nr++;
      miso = (nr < 32) ? pat[31-nr] : 1'b0;
    end
    ps = sclk; pc = cs_n; pm = mosi;
  end

  task automatic run(input bit r, input logic [5:0] a, input logic [1:0] n_in,
                     input logic [23:0] wd, input logic [31:0] p, input int poke);
    int n, nb, f0, cg, g, bad_ph, dcyc;
    logic [7:0] cmd;
    logic [23:0] mask, exp_r;
    n  = (n_in == 2'd0) ? 1 : int'(n_in);
    nb = 8 * (n + 1);
    f0 = frames;
    pat = p;
    @(negedge clk);
    start = 1'b1; rd = r; addr = a; nbytes = n_in; wdata = wd;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && cs_n === 1'b0, "R10 busy/cs after start", int'(busy), 1);
    for (int k = 0; k < 5000 && done !== 1'b1; k++) begin
      if (k == poke) begin start = 1'b1; rd = 1'b0; addr = 6'h33; nbytes = 2'd3; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    dcyc = cyc;
    chk(done === 1'b1 && busy === 1'b0, "R10 done/busy at end", int'(done), 1);
    chk(dcyc == csr + 1, "R11 done one cycle after cs_n rise", dcyc, csr + 1);
    chk(nf == nb, "R3 falling edge count", nf, nb);
    cmd = 8'((got >> (nb - 8)) & 32'hFF);
    chk(cmd == {~r, 1'b0, a}, "R2 command byte", int'(cmd), int'({~r, 1'b0, a}));
    mask = 24'((32'h1 << (8 * n)) - 1);
    if (!r) begin
      chk((got[23:0] & mask) == (wd & mask), "R3 write bytes", int'(got[23:0] & mask), int'(wd & mask));
      chk(rdata == 24'h0, "R11 rdata after write", int'(rdata), 0);
    end else begin
      exp_r = p[23:0] >> (8 * (3 - n));
      chk(rdata == exp_r, "R5 read data", int'(rdata), int'(exp_r));
    end
    chk(fall_c[0] - csf >= SETUP, "R6 cs setup", fall_c[0] - csf, SETUP);
    bad_ph = 0;
    for (int i = 0; i < nb; i++) begin
      if (rise_c[i] - fall_c[i] < HALF) bad_ph++;
      if (i % 8 != 0 && fall_c[i] - rise_c[i-1] < HALF) bad_ph++;
    end
    chk(bad_ph == 0, "R6 sclk phases", bad_ph, 0);
    cg = !r ? GAP : (a == WAVE) ? RDWW : RDW;
    g = fall_c[8] - rise_c[7];
    if (r) chk(g >= cg && g <= cg + HALF, "R7 read command pause", g, cg);
    else   chk(g >= cg, "R8 write command gap", g, cg);
    for (int b = 2; b <= n; b++) begin
      g = fall_c[8*b] - rise_c[8*b-1];
      chk(g >= GAP, "R8 data byte gap", g, GAP);
    end
    chk(csr - fall_c[nb-1] >= HOLD, "R9 cs hold", csr - fall_c[nb-1], HOLD);
    chk(hold_err == 0 && setup_err == 0, "R4 mosi stability", hold_err + setup_err, 0);
    @(negedge clk);
    chk(done === 1'b0, "R11 done width", int'(done), 0);
    repeat (30) @(negedge clk);
    chk(frames == f0 + 1 && cs_n === 1'b1 && sclk === 1'b1, "R10 single frame, idle after",
        frames - f0, 1);
  endtask

  task automatic t_reset();
    chk(cs_n === 1'b1 && sclk === 1'b1, "R1 link idle in reset", int'(cs_n & sclk), 1);
    chk(busy === 1'b0 && done === 1'b0 && rdata === 24'h0, "R1 status in reset", int'(busy | done), 0);
  endtask

  task automatic t_writes();
    run(1'b0, 6'h2A, 2'd1, 24'h0000A5, 32'h0, -1);
    run(1'b0, 6'h15, 2'd2, 24'h00C35A, 32'h0, -1);
    run(1'b0, 6'h3F, 2'd3, 24'h123456, 32'h0, -1);
  endtask

  task automatic t_reads();
    run(1'b1, 6'h0C, 2'd3, 24'h0, {8'h00, 24'h9A5C37}, -1);
    run(1'b1, 6'h07, 2'd2, 24'h0, {8'hFF, 24'hE1B400}, -1);
    run(1'b1, 6'h1D, 2'd1, 24'h0, {8'h00, 24'h6D0000}, -1);
  endtask

  task automatic t_wave_read();
    run(1'b1, WAVE, 2'd3, 24'h0, {8'h00, 24'hF00F55}, -1);
  endtask

  task automatic t_zero_count();
    run(1'b0, 6'h09, 2'd0, 24'hFFFF3C, 32'h0, -1);
  endtask

  task automatic t_start_busy();
    run(1'b1, 6'h22, 2'd2, 24'h0, {8'h00, 24'h5AA500}, 40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_writes();
    t_reads();
    t_wave_read();
    t_zero_count();
    t_start_busy();
    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule